// File: doc/BRIEF.md
# External Bus Cycle Wait-State Controller

This block runs single read and write cycles on an external memory bus on behalf of a bus master. The core side offers one request at a time: an address, a read/write flag and write data. The block then drives active-low read and write strobes, the address, and the output enables for a 24-bit data bus. When the cycle ends, it returns a one-clock done pulse and, for reads, the captured read data.

The length of each cycle is set by two things, and the longer one wins. One is a programmed minimum wait-state count, from 0 to 15. The other is an external acknowledge input that can hold the cycle open for as long as it stays deasserted. A cycle programmed with zero wait states always takes exactly one clock. A mode input chooses how the acknowledge is sampled: either directly, when it is already synchronous to the bus clock, or through a two-flop synchronizer, which delays recognition by two clocks.

Bus ownership is a single input. A halt input stands for the stop and wait low-power states. While the block does not own the bus, is halted, or is in reset, it releases the strobe drivers and ignores the acknowledge.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: `rd_n_o` and `wr_n_o` are active-low. Only one of them is low at any time, and only while a cycle is running. `rd_n_o` is low for reads and `wr_n_o` is low for writes.
- R2: `strobe_oe_o` is 0 whenever `own_bus_i` is 0, `halt_i` is 1, or `rst` is 1. Otherwise it is 1.
- R3: If `min_wait_i` = W (1 to 15) at acceptance and acknowledge is already recognised, the strobe stays low for exactly W+1 clocks.
- R4: Acknowledge is asserted when `ack_n_i` = 0. In synchronous mode (`ack_async_i` = 0), acknowledge first driven low during strobe clock d (counted from 0) gives a strobe length of max(d, W)+1 clocks. There is no upper limit on d.
- R5: If `min_wait_i` = 0 at acceptance, the strobe is low for exactly 1 clock, whatever the value of `ack_n_i`.
- R6: In synchronized mode (`ack_async_i` = 1), the same stimulus gives a strobe length of max(d+2, W)+1 clocks.
- R7: An acknowledge asserted while no cycle is running causes no strobe and no `done_o`.
- R8: `done_o` is high for exactly the one clock after the last strobe clock. On a read, `rdata_o` then holds the `data_i` value sampled on the last strobe clock.
- R9: On a write, `data_oe_o` is 1 and `data_o` carries the write data for every strobe clock and for one clock after the cycle. `data_oe_o` is 0 at all other times, including during reads.
- R10: A request (`req_valid_i` = 1) is taken only while `req_ready_o` = 1. `req_ready_o` is 1 only when no cycle is running, `own_bus_i` = 1 and `halt_i` = 0. While a cycle runs, `addr_o` shows the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Stop/wait state: freeze the sequencer, release the strobes |
| own_bus_i | input | 1 | This block is bus master |
| min_wait_i | input | 4 | Programmed minimum wait states |
| ack_async_i | input | 1 | 1: acknowledge passes through the synchronizer |
| req_valid_i | input | 1 | Core request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 24 | Request write data |
| req_ready_o | output | 1 | Request can be taken this clock |
| done_o | output | 1 | Cycle complete pulse |
| rdata_o | output | 24 | Captured read data |
| ack_n_i | input | 1 | External transfer acknowledge, active low |
| addr_o | output | 16 | External address |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| strobe_oe_o | output | 1 | Output enable for the strobe drivers |
| data_i | input | 24 | External data bus, input side |
| data_o | output | 24 | External data bus, output side |
| data_oe_o | output | 1 | Output enable for the data bus drivers |

## Verification
Some checks run on every cycle: the strobes are never low together and never low outside a cycle, and the strobe drivers are released whenever ownership is lost or the block is halted. The data drivers never overlap a read strobe, done is a single-clock pulse, and no cycle ends before its programmed minimum. Other behaviour can only be shown by the bench scenarios. These are: the exact cycle length as the maximum of the minimum count and a late acknowledge, the two extra clocks of the synchronized path, zero-wait cycles that ignore a missing acknowledge, a very long stretch, the captured read data, and the one-clock tail on the write data drivers.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int XB_DATA_W = 24;
    localparam int XB_WAIT_W = 4;

    typedef enum logic {
        XB_IDLE   = 1'b0,
        XB_ACTIVE = 1'b1
    } xb_state_e;

    typedef struct packed {
        logic write;
        logic zero_wait;
    } xb_cyc_t;

    // Effective acknowledge: raw pin (active low) or synchronized copy
    function automatic logic xb_ack_pick(input logic async_mode,
                                         input logic raw_n,
                                         input logic synced);
        return async_mode ? synced : ~raw_n;
    endfunction
endpackage

// File: rtl/xbus_ack_sync.sv
module xbus_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_n_i,
    output logic ack_sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], ~ack_n_i};
    end

    assign ack_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] load_val_i,
    input  logic              step_i,
    output logic              expired_o
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                        cnt_q <= '0;
        else if (load_i)                cnt_q <= load_val_i;
        else if (step_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = XB_DATA_W,
    parameter int WAIT_W = XB_WAIT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_i,
    input  logic              own_bus_i,
    input  logic [WAIT_W-1:0] min_wait_i,
    input  logic              ack_async_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              ack_n_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              strobe_oe_o,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);
    localparam int LEN_W = 16;

    xb_state_e         st_q;
    xb_cyc_t           cyc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              doe_q;

    logic accept, run, finish, timer_expired, ack_synced, ack_eff;

    assign req_ready_o = (st_q == XB_IDLE) && own_bus_i && !halt_i;
    assign accept      = req_ready_o && req_valid_i;
    assign run         = (st_q == XB_ACTIVE) && !halt_i;

    xbus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .ack_n_i    (ack_n_i),
        .ack_sync_o (ack_synced)
    );

    xbus_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .load_val_i (min_wait_i),
        .step_i     (run),
        .expired_o  (timer_expired)
    );

    assign ack_eff = xb_ack_pick(ack_async_i, ack_n_i, ack_synced);
    assign finish  = run && timer_expired && (cyc_q.zero_wait || ack_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= XB_IDLE;
            cyc_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            doe_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                st_q            <= XB_ACTIVE;
                cyc_q.write     <= req_write_i;
                cyc_q.zero_wait <= (min_wait_i == '0);
                addr_q          <= req_addr_i;
                wdata_q         <= req_wdata_i;
                doe_q           <= req_write_i;
            end else if (finish) begin
                st_q <= XB_IDLE;
                if (!cyc_q.write) rdata_q <= data_i;
                doe_q <= cyc_q.write;     // one-clock tail after a write
            end else if (st_q == XB_IDLE) begin
                doe_q <= 1'b0;
            end
        end
    end

    assign rd_n_o      = !((st_q == XB_ACTIVE) && !cyc_q.write);
    assign wr_n_o      = !((st_q == XB_ACTIVE) &&  cyc_q.write);
    assign strobe_oe_o = own_bus_i && !halt_i && !rst;
    assign addr_o      = addr_q;
    assign data_o      = wdata_q;
    assign data_oe_o   = doe_q;
    assign done_o      = done_q;
    assign rdata_o     = rdata_q;

    // ---------------- assertions ----------------
    logic [LEN_W-1:0]  len_q;
    logic [WAIT_W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            wait_q <= '0;
        end else if (accept) begin
            len_q  <= LEN_W'(1);
            wait_q <= min_wait_i;
        end else if (run && !finish && len_q != '1) begin
            len_q <= len_q + 1'b1;
        end
    end

    // R1: strobes mutually exclusive and only inside a cycle
    a_r1_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !wr_n_o));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (st_q == XB_IDLE) |-> (rd_n_o && wr_n_o));
    // R2: drivers released without ownership or while halted
    a_r2_release: assert property (@(posedge clk) disable iff (rst)
        (!own_bus_i || halt_i) |-> !strobe_oe_o);
    // R3: no cycle ends before its programmed minimum
    a_r3_min_len: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (len_q >= LEN_W'(wait_q) + LEN_W'(1)));
    // R5: a zero-wait cycle lasts one running clock
    a_r5_zero_wait: assert property (@(posedge clk) disable iff (rst)
        ((st_q == XB_ACTIVE) && cyc_q.zero_wait && !halt_i) |=> (st_q == XB_IDLE));
    // R8: done is a single-clock pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R9: data drivers never overlap a read strobe
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !rd_n_o |-> !data_oe_o);
    // R10: a request is never taken while a cycle runs
    a_r10_busy: assert property (@(posedge clk) disable iff (rst)
        (st_q == XB_ACTIVE) |-> !req_ready_o);
endmodule

// File: tb/xbus_wait_ctrl_tb.sv
module xbus_wait_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt_i = 1'b0;
    logic        own_bus_i = 1'b1;
    logic [3:0]  min_wait_i = 4'd0;
    logic        ack_async_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [15:0] req_addr_i = '0;
    logic [23:0] req_wdata_i = '0;
    logic        req_ready_o, done_o;
    logic [23:0] rdata_o;
    logic        ack_n_i = 1'b1;
    logic [15:0] addr_o;
    logic        rd_n_o, wr_n_o, strobe_oe_o;
    logic [23:0] data_i = '0;
    logic [23:0] data_o;
    logic        data_oe_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xbus_wait_ctrl u_dut (
        .clk(clk), .rst(rst), .halt_i(halt_i), .own_bus_i(own_bus_i),
        .min_wait_i(min_wait_i), .ack_async_i(ack_async_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .req_ready_o(req_ready_o), .done_o(done_o), .rdata_o(rdata_o),
        .ack_n_i(ack_n_i), .addr_o(addr_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
        .strobe_oe_o(strobe_oe_o), .data_i(data_i), .data_o(data_o),
        .data_oe_o(data_oe_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One bus cycle; ack_n driven low at strobe clock d (d < 0: never).
    task automatic bus_cycle(input logic wr, input logic [3:0] w, input logic amode,
                             input int d, input int exp_len, input string tag);
        int   n = 0;
        logic seen_done = 1'b0;
        logic [23:0] wd = 24'h5A0000 ^ {8'd0, 12'd0, w, 4'(d)};
        logic [15:0] ad = 16'h1200 + 16'(exp_len);
        @(negedge clk);
        min_wait_i = w; ack_async_i = amode; ack_n_i = 1'b1;
        req_write_i = wr; req_addr_i = ad; req_wdata_i = wd;
        data_i = 24'hC3_0000 + 24'(exp_len);
        check({tag, " R10 ready"}, req_ready_o, 1);
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        for (int k = 0; k < 2000 && !seen_done; k++) begin
            if (!rd_n_o || !wr_n_o) begin
                if (n == d) ack_n_i = 1'b0;
                if (n == 0) begin
                    check({tag, " R1 strobe kind"}, {rd_n_o, wr_n_o}, wr ? 2'b10 : 2'b01);
                    check({tag, " R10 addr"}, addr_o, ad);
                end
                if (wr) check({tag, " R9 data drive"}, {data_oe_o, data_o}, {1'b1, wd});
                else    check({tag, " R9 no drive on read"}, data_oe_o, 0);
                n++;
            end
            if (done_o) begin
                seen_done = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
        check({tag, " done seen"}, seen_done, 1);
        check({tag, " length"}, n, exp_len);
        check({tag, " R1 strobes high at done"}, {rd_n_o, wr_n_o}, 2'b11);
        if (!wr) check({tag, " R8 rdata"}, rdata_o, 24'hC3_0000 + 24'(exp_len));
        check({tag, " R9 tail"}, data_oe_o, wr);
        ack_n_i = 1'b1;
        @(negedge clk);
        check({tag, " R8 done one clock"}, done_o, 0);
        check({tag, " R9 released"}, data_oe_o, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R2 oe in reset", strobe_oe_o, 0);
        check("R1 strobes in reset", {rd_n_o, wr_n_o}, 2'b11);
        check("R9 data oe in reset", data_oe_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 oe after reset", strobe_oe_o, 1);
        check("R8 done after reset", done_o, 0);
    endtask

    task automatic t_idle_ack;
        @(negedge clk);
        ack_async_i = 1'b0; ack_n_i = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check("R7 no strobe on idle ack", {rd_n_o, wr_n_o}, 2'b11);
            check("R7 no done on idle ack", done_o, 0);
        end
        ack_n_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_no_owner;
        @(negedge clk);
        own_bus_i = 1'b0;
        #1;
        check("R2 oe without ownership", strobe_oe_o, 0);
        check("R10 ready without ownership", req_ready_o, 0);
        req_valid_i = 1'b1; req_write_i = 1'b0;
        @(negedge clk);
        req_valid_i = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check("R10 request ignored", {rd_n_o, wr_n_o, done_o}, 3'b110);
        end
        own_bus_i = 1'b1;
        halt_i = 1'b1;
        #1;
        check("R2 oe while halted", strobe_oe_o, 0);
        check("R10 ready while halted", req_ready_o, 0);
        @(negedge clk);
        halt_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_idle_ack();
        // R3: minimum governs when ack already present
        bus_cycle(1'b0, 4'd3,  1'b0, 0,  4,  "R3 read w3");
        bus_cycle(1'b1, 4'd15, 1'b0, 0,  16, "R3 write w15");
        // R4: late ack stretches, including a long stretch
        bus_cycle(1'b0, 4'd2,  1'b0, 5,  6,  "R4 read late ack");
        bus_cycle(1'b1, 4'd1,  1'b0, 60, 61, "R4 write long stretch");
        bus_cycle(1'b0, 4'd6,  1'b0, 4,  7,  "R4 early ack");
        // R5: zero wait ignores absent ack
        bus_cycle(1'b0, 4'd0,  1'b0, -1, 1,  "R5 read zero wait");
        bus_cycle(1'b1, 4'd0,  1'b1, -1, 1,  "R5 write zero wait");
        // R6: synchronized path
        bus_cycle(1'b0, 4'd1,  1'b1, 3,  6,  "R6 read async");
        bus_cycle(1'b1, 4'd8,  1'b1, 2,  9,  "R6 write async min");
        t_no_owner();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule